// File: doc/BRIEF.md
# Tuple Space Rule Lookup Engine

This engine classifies a header made of two fixed-width fields against a set of prefix rules. A rule gives a prefix length for each field. The pair of lengths selects one of several small exact-match tables, so every rule lives in exactly one table. Inside that table the rule is stored under its masked prefix bits. Each table is a hashed array of buckets, and each bucket holds a small set of ways. An entry keeps a valid bit, the masked key, a priority number and the rule index that is returned on a hit.

A query captures both header fields, together with a snapshot of which tables hold at least one rule. The engine then visits those tables one per cycle. For each one it cuts both fields down to that table's lengths, hashes the masked pair to pick a bucket, and compares the ways. The best hit seen so far is carried forward, and the winner is reported with a one-cycle result pulse. Inserts and deletes use a separate update port. Each one touches a single bucket of a single table, and the engine takes it only while it is idle.

Top module: `tuple_lookup`

## Requirements
- R1: After reset `q_ready` is 1, `res_valid` is 0, `upd_ovf` is 0 and every table is empty.
- R2: A rule with lengths (la, lb) and keys (ka, kb) matches a query (a, b) exactly when the top la bits of a equal the top la bits of ka and the top lb bits of b equal the top lb bits of kb. Key bits below the length are discarded when the rule is inserted.
- R3: A length of 0 makes its field a full wildcard, so a rule with lengths (0,0) matches every query.
- R4: Among all matching rules the lowest priority number wins. On equal priority the rule in the table with the lower index la*(W+1)+lb wins, then the lower way.
- R5: A query with no matching rule returns `res_hit`=0 and `res_id`=0.
- R6: Let n be the number of tables holding at least one rule when a query is accepted. `res_valid` is then a single-cycle pulse exactly n+1 clock edges after the accepting edge. `q_ready` is low from the accepting edge until that pulse.
- R7: The bucket is the XOR fold of the masked key {a_masked, b_masked}: key bit i feeds bucket bit i mod log2(BUCKETS). With the defaults this is a_masked XOR b_masked. An insert into a bucket whose WAYS entries are all valid pulses `upd_ovf` on the next cycle and leaves the table unchanged.
- R8: A delete removes every entry in the rule's table whose masked key equals the given masked key. A table emptied this way is no longer probed.
- R9: Updates and queries are taken only while `q_ready` is 1. An update offered while the engine is busy, or in the same cycle as an accepted query, has no effect.
- R10: `upd_ovf` stays 0 after deletes, after inserts that find a free way, and in all cycles without an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request |
| upd_del | input | 1 | 1 = delete, 0 = insert |
| upd_len_a | input | LW | Prefix length of field A |
| upd_len_b | input | LW | Prefix length of field B |
| upd_key_a | input | W | Prefix bits of field A |
| upd_key_b | input | W | Prefix bits of field B |
| upd_prio | input | PW | Priority number (lower wins) |
| upd_id | input | IW | Rule index returned on hit |
| upd_ovf | output | 1 | Insert rejected, bucket full |
| q_valid | input | 1 | Query request |
| q_ready | output | 1 | Engine idle, query or update accepted |
| q_a | input | W | Header field A |
| q_b | input | W | Header field B |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | A rule matched |
| res_id | output | IW | Index of the winning rule |

## Verification
The bench builds the engine with its defaults: 3-bit fields (16 tables), 8 buckets of 2 ways, 4-bit priorities and 6-bit indices. Two ways per bucket make an overflow reachable with three inserts that hash alike. The 16 tables cover both extremes, the full wildcard (0,0) and the exact match (3,3). Between them there are enough tables to build a priority tie across two of them and to watch the latency shrink as a table empties.

// File: rtl/tuple_lookup.sv
module tuple_lookup #(
  parameter int W       = 3,
  parameter int BUCKETS = 8,
  parameter int WAYS    = 2,
  parameter int PW      = 4,
  parameter int IW      = 6,
  localparam int LW     = $clog2(W + 1),
  localparam int NT     = (W + 1) * (W + 1),
  localparam int TW     = $clog2(NT),
  localparam int BW     = $clog2(BUCKETS),
  localparam int KW     = 2 * W,
  localparam int WYW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic          upd_del,
  input  logic [LW-1:0] upd_len_a,
  input  logic [LW-1:0] upd_len_b,
  input  logic [W-1:0]  upd_key_a,
  input  logic [W-1:0]  upd_key_b,
  input  logic [PW-1:0] upd_prio,
  input  logic [IW-1:0] upd_id,
  output logic          upd_ovf,
  input  logic          q_valid,
  output logic          q_ready,
  input  logic [W-1:0]  q_a,
  input  logic [W-1:0]  q_b,
  output logic          res_valid,
  output logic          res_hit,
  output logic [IW-1:0] res_id
);

  function automatic logic [W-1:0] pmask(input logic [LW-1:0] l);
    pmask = '0;
    for (int i = 0; i < W; i++) pmask[i] = (i >= W - int'(l));
  endfunction

  function automatic logic [BW-1:0] fold(input logic [KW-1:0] k);
    fold = '0;
    for (int i = 0; i < KW; i++) fold[i % BW] = fold[i % BW] ^ k[i];
  endfunction

  logic          ent_v [NT][BUCKETS][WAYS];
  logic [KW-1:0] ent_k [NT][BUCKETS][WAYS];
  logic [PW-1:0] ent_p [NT][BUCKETS][WAYS];
  logic [IW-1:0] ent_i [NT][BUCKETS][WAYS];

  logic          busy;
  logic [NT-1:0] pend, active;
  logic [W-1:0]  qa, qb;
  logic          best_hit;
  logic [PW-1:0] best_p;
  logic [IW-1:0] best_id;

  assign q_ready = !busy;

  always_comb begin
    active = '0;
    for (int t = 0; t < NT; t++)
      for (int b = 0; b < BUCKETS; b++)
        for (int w = 0; w < WAYS; w++)
          if (ent_v[t][b][w]) active[t] = 1'b1;
  end

  logic [TW-1:0]  u_t;
  logic [KW-1:0]  u_key;
  logic [BW-1:0]  u_b;
  logic           u_full;
  logic [WYW-1:0] u_way;

  assign u_t   = TW'(int'(upd_len_a) * (W + 1) + int'(upd_len_b));
  assign u_key = {upd_key_a & pmask(upd_len_a), upd_key_b & pmask(upd_len_b)};
  assign u_b   = fold(u_key);

  always_comb begin
    u_full = 1'b1;
    u_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!ent_v[u_t][u_b][w]) begin
        u_full = 1'b0;
        u_way  = WYW'(w);
      end
  end

  logic [TW-1:0] cur;
  logic [LW-1:0] c_la, c_lb;
  logic [KW-1:0] c_key;
  logic [BW-1:0] c_b;
  logic          p_hit;
  logic [PW-1:0] p_pr;
  logic [IW-1:0] p_id;

  always_comb begin
    cur = '0;
    for (int t = NT - 1; t >= 0; t--)
      if (pend[t]) cur = TW'(t);
  end

  assign c_la  = LW'(int'(cur) / (W + 1));
  assign c_lb  = LW'(int'(cur) % (W + 1));
  assign c_key = {qa & pmask(c_la), qb & pmask(c_lb)};
  assign c_b   = fold(c_key);

  always_comb begin
    p_hit = 1'b0;
    p_pr  = '0;
    p_id  = '0;
    for (int w = 0; w < WAYS; w++)
      if (ent_v[cur][c_b][w] && ent_k[cur][c_b][w] == c_key &&
          (!p_hit || ent_p[cur][c_b][w] < p_pr)) begin
        p_hit = 1'b1;
        p_pr  = ent_p[cur][c_b][w];
        p_id  = ent_i[cur][c_b][w];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= '0;
      qa        <= '0;
      qb        <= '0;
      best_hit  <= 1'b0;
      best_p    <= '0;
      best_id   <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_id    <= '0;
      upd_ovf   <= 1'b0;
      for (int t = 0; t < NT; t++)
        for (int b = 0; b < BUCKETS; b++)
          for (int w = 0; w < WAYS; w++) begin
            ent_v[t][b][w] <= 1'b0;
            ent_k[t][b][w] <= '0;
            ent_p[t][b][w] <= '0;
            ent_i[t][b][w] <= '0;
          end
    end else begin
      res_valid <= 1'b0;
      upd_ovf   <= 1'b0;
      if (!busy) begin
        if (upd_valid && !q_valid) begin
          if (upd_del) begin
            for (int w = 0; w < WAYS; w++)
              if (ent_v[u_t][u_b][w] && ent_k[u_t][u_b][w] == u_key)
                ent_v[u_t][u_b][w] <= 1'b0;
          end else if (u_full) begin
            upd_ovf <= 1'b1;
          end else begin
            ent_v[u_t][u_b][u_way] <= 1'b1;
            ent_k[u_t][u_b][u_way] <= u_key;
            ent_p[u_t][u_b][u_way] <= upd_prio;
            ent_i[u_t][u_b][u_way] <= upd_id;
          end
        end
        if (q_valid) begin
          busy     <= 1'b1;
          pend     <= active;
          qa       <= q_a;
          qb       <= q_b;
          best_hit <= 1'b0;
          best_p   <= '0;
          best_id  <= '0;
        end
      end else if (pend == '0) begin
        busy      <= 1'b0;
        res_valid <= 1'b1;
        res_hit   <= best_hit;
        res_id    <= best_hit ? best_id : '0;
      end else begin
        pend[cur] <= 1'b0;
        if (p_hit && (!best_hit || p_pr < best_p)) begin
          best_hit <= 1'b1;
          best_p   <= p_pr;
          best_id  <= p_id;
        end
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> !q_ready);

  a_r6_result_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pend == '0 |=> res_valid && q_ready);

  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ovf |-> $past(upd_valid && !upd_del && !q_valid && q_ready));

  a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(active));

  a_r5_miss_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_id == '0);

endmodule

// File: tb/tuple_lookup_tb.sv
module tuple_lookup_tb;
  localparam int W = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       upd_valid = 0, upd_del = 0;
  logic [1:0] upd_len_a = 0, upd_len_b = 0;
  logic [2:0] upd_key_a = 0, upd_key_b = 0;
  logic [3:0] upd_prio = 0;
  logic [5:0] upd_id = 0;
  logic       upd_ovf;
  logic       q_valid = 0, q_ready;
  logic [2:0] q_a = 0, q_b = 0;
  logic       res_valid, res_hit;
  logic [5:0] res_id;

  always #4 clk = ~clk;

  tuple_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_del(upd_del),
    .upd_len_a(upd_len_a), .upd_len_b(upd_len_b),
    .upd_key_a(upd_key_a), .upd_key_b(upd_key_b),
    .upd_prio(upd_prio), .upd_id(upd_id), .upd_ovf(upd_ovf),
    .q_valid(q_valid), .q_ready(q_ready), .q_a(q_a), .q_b(q_b),
    .res_valid(res_valid), .res_hit(res_hit), .res_id(res_id)
  );

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int r_la[$], r_lb[$], r_ka[$], r_kb[$], r_p[$], r_id[$];
  int m_cnt = 0, p_n = 0, p_hit = 0, p_id = 0;
  bit m_rv = 0, m_ovf = 0, m_hit = 0, rdy = 0;
  int m_id = 0;

  function automatic int msk(int v, int l);
    return (v >> (W - l)) << (W - l);
  endfunction

  task automatic model_update();
    int la = upd_len_a, lb = upd_len_b;
    int ka = msk(upd_key_a, la), kb = msk(upd_key_b, lb);
    if (upd_del) begin
      for (int i = r_la.size() - 1; i >= 0; i--)
        if (r_la[i] == la && r_lb[i] == lb && r_ka[i] == ka && r_kb[i] == kb) begin
          r_la.delete(i); r_lb.delete(i); r_ka.delete(i);
          r_kb.delete(i); r_p.delete(i); r_id.delete(i);
        end
    end else begin
      int same = 0;
      for (int i = 0; i < r_la.size(); i++)
        if (r_la[i] == la && r_lb[i] == lb && (r_ka[i] ^ r_kb[i]) == (ka ^ kb)) same++;
      if (same >= 2) m_ovf = 1;
      else begin
        r_la.push_back(la); r_lb.push_back(lb); r_ka.push_back(ka);
        r_kb.push_back(kb); r_p.push_back(upd_prio); r_id.push_back(upd_id);
      end
    end
  endtask

  task automatic model_query(input int a, input int b);
    bit [15:0] seen = 0;
    int bp = 0, bt = 0;
    p_hit = 0; p_id = 0;
    for (int i = 0; i < r_la.size(); i++) begin
      int t = r_la[i] * (W + 1) + r_lb[i];
      seen[t] = 1;
      if (msk(a, r_la[i]) == r_ka[i] && msk(b, r_lb[i]) == r_kb[i])
        if (!p_hit || r_p[i] < bp || (r_p[i] == bp && t < bt)) begin
          p_hit = 1; p_id = r_id[i]; bp = r_p[i]; bt = t;
        end
    end
    p_n = $countones(seen);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_rv = 0; m_ovf = 0; m_hit = 0; m_id = 0;
    end else begin
      rdy = (m_cnt == 0);
      m_rv = 0; m_ovf = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_rv = 1; m_hit = p_hit[0]; m_id = p_id; end
      end
      if (rdy && upd_valid && !q_valid) model_update();
      if (rdy && q_valid) begin model_query(q_a, q_b); m_cnt = p_n + 1; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(q_ready == (m_cnt == 0), "R6", "q_ready", q_ready, m_cnt == 0);
    chk(res_valid == m_rv, "R6", "res_valid", res_valid, m_rv);
    chk(upd_ovf == m_ovf, m_ovf ? "R7" : "R10", "upd_ovf", upd_ovf, m_ovf);
    if (m_rv) begin
      chk(res_hit == m_hit, cur_req, "res_hit", res_hit, m_hit);
      chk(res_id == m_id, cur_req, "res_id", res_id, m_id);
    end
  end

  task automatic idle_wait();
    while (!q_ready) @(negedge clk);
  endtask

  task automatic upd(input bit del, input int la, input int lb, input int ka, input int kb, input int p, input int id);
    idle_wait();
    upd_valid = 1; upd_del = del; upd_len_a = la[1:0]; upd_len_b = lb[1:0];
    upd_key_a = ka[2:0]; upd_key_b = kb[2:0]; upd_prio = p[3:0]; upd_id = id[5:0];
    @(negedge clk);
    upd_valid = 0; upd_del = 0;
  endtask

  task automatic query(input string req, input int a, input int b, input bit busy_upd);
    idle_wait();
    cur_req = req;
    q_valid = 1; q_a = a[2:0]; q_b = b[2:0];
    @(negedge clk);
    q_valid = 0;
    if (busy_upd) begin
      upd_valid = 1; upd_del = 0; upd_len_a = 2; upd_len_b = 2;
      upd_key_a = 3'b100; upd_key_b = 3'b100; upd_prio = 0; upd_id = 7;
      @(negedge clk);
      upd_valid = 0;
    end
    for (int i = 0; i < 40 && !q_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(q_ready == 1, "R1", "q_ready after reset", q_ready, 1);
    chk(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);
    chk(upd_ovf == 0, "R1", "upd_ovf after reset", upd_ovf, 0);
    query("R1", 0, 0, 0);
    query("R5", 5, 2, 0);
    upd(0, 2, 1, 3'b000, 3'b000, 5, 1);
    query("R2", 3'b001, 3'b011, 0);
    query("R5", 3'b010, 3'b000, 0);
    upd(0, 0, 0, 3'b000, 3'b000, 9, 2);
    query("R3", 3'b111, 3'b111, 0);
    query("R4", 3'b000, 3'b000, 0);
    upd(0, 3, 3, 3'b000, 3'b000, 2, 3);
    query("R4", 3'b000, 3'b000, 0);
    upd(0, 3, 3, 3'b001, 3'b001, 7, 4);
    upd(0, 3, 3, 3'b010, 3'b010, 3, 5);
    query("R7", 3'b010, 3'b010, 0);
    upd(0, 1, 0, 3'b111, 3'b101, 1, 6);
    query("R2", 3'b100, 3'b000, 0);
    query("R9", 3'b000, 3'b001, 1);
    query("R9", 3'b100, 3'b100, 0);
    upd(1, 0, 0, 3'b000, 3'b000, 0, 0);
    query("R8", 3'b011, 3'b111, 0);
    upd(0, 1, 1, 3'b000, 3'b000, 2, 8);
    query("R4", 3'b000, 3'b000, 0);
    upd(1, 3, 3, 3'b000, 3'b000, 0, 0);
    upd(1, 3, 3, 3'b001, 3'b001, 0, 0);
    query("R8", 3'b000, 3'b000, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule